// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host reach a small bank of 8-bit controller registers through a single 64-bit command word. The host writes the word with the busy flag (bit 63) set. The word also carries a direction flag, a 4-bit opcode, a 3-bit extended selector and a data byte. The bridge decodes the opcode and selector into one internal target. After a fixed number of cycles it issues a single-cycle read or write strobe on a select/strobe/data bus, then clears the busy flag in the same word.

On a read, the byte returned by the selected register replaces bits 7:0 of the word. The host polls the word until bit 63 drops and then takes the byte from the low bits. While an access is pending, further host writes have no effect. An opcode/selector pair that the bridge does not recognise is retired straight away and produces no bus cycle. The registers themselves sit outside the block, on the bus side.

Top module: `ind_reg_bridge`

## Requirements
- R1: While reset is asserted and right after it, host_rdata reads 0 and neither bus_wr nor bus_rd is asserted.
- R2: A host write whose data has bit 63 set, made while host_rdata bit 63 is 0, is accepted and stored whole. For a recognised target, host_rdata bit 63 then reads 1 for exactly ACCESS_LAT cycles and clears at the ACCESS_LAT-th clock edge after acceptance.
- R3: A host write is ignored and leaves host_rdata unchanged in two cases: it arrives while host_rdata bit 63 is 1, or its data has bit 63 clear.
- R4: Decoding uses opcode bits 60:57 and extended bits 34:32, with bus_sel codes as follows.
  - Opcode 4 gives code 5 (clock high phase), whatever the extended bits hold.
  - Opcode 6 uses the extended bits. Extended 1 gives code 1 (data) and extended 2 gives code 2 (control).
  - Extended 3 gives code 3 (clock control) for a write and code 4 (status) for a read.
  - Extended 7 gives code 6 (core reset), for writes only.
- R5: Each recognised access produces exactly one strobe, lasting one cycle, in the last cycle in which bit 63 reads 1. The strobe is bus_wr when bit 56 is 0 and bus_rd when bit 56 is 1. bus_wdata equals bits 7:0 of the accepted word.
- R6: When a read completes, bits 7:0 of host_rdata take the bus_rdata value sampled at the strobe. Bits 62:8 keep the accepted values.
- R7: An unrecognised pair completes one cycle after acceptance, with no strobe. On a read it returns 0x00 in bits 7:0. Unrecognised pairs include:
  - any opcode other than 4 or 6;
  - opcode 6 with extended 0, 4, 5 or 6;
  - a read of extended 7.
- R8: After completion, bits 7:0 stay unchanged until the next accepted command. A completed write leaves the written byte in place.
- R9: A write to extended selector 7 drives a bus_wr strobe with bus_sel code 6. A status read issued after it returns 0xF8 from the reset register bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write enable for the command word |
| host_wdata | input | 64 | Command word written by the host |
| host_rdata | output | 64 | Current command word; bit 63 is the busy flag, bits 7:0 hold the result |
| bus_sel | output | 3 | Internal target code |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_rd | output | 1 | One-cycle read strobe |
| bus_wdata | output | 8 | Byte to be written |
| bus_rdata | input | 8 | Byte returned by the selected register, valid during bus_rd |

## Verification
The bench builds the bridge with ACCESS_LAT set to 3 rather than the default 4. This keeps every access short and lets busy-window writes land at both the start and the end of the window. With this value, the host-visible busy length can be counted and compared against a value other than the default. The bench also exercises every decoded target, the unrecognised pairs that retire in a single cycle, and a core reset followed by a status read.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  localparam int WORD_W  = 64;
  localparam int BYTE_W  = 8;
  localparam int BUSY_B  = 63;
  localparam int READ_B  = 56;
  localparam int OP_HI   = 60;
  localparam int OP_LO   = 57;
  localparam int EXT_HI  = 34;
  localparam int EXT_LO  = 32;
  localparam int OP_W    = OP_HI - OP_LO + 1;
  localparam int EXT_W   = EXT_HI - EXT_LO + 1;

  localparam logic [OP_W-1:0]  OPC_CLKHI = 4'd4;
  localparam logic [OP_W-1:0]  OPC_EXT   = 4'd6;
  localparam logic [EXT_W-1:0] EXT_DATA  = 3'd1;
  localparam logic [EXT_W-1:0] EXT_CTL   = 3'd2;
  localparam logic [EXT_W-1:0] EXT_CKST  = 3'd3;
  localparam logic [EXT_W-1:0] EXT_RST   = 3'd7;

  typedef enum logic [2:0] {
    TGT_NONE   = 3'd0,
    TGT_DATA   = 3'd1,
    TGT_CTL    = 3'd2,
    TGT_CLKCTL = 3'd3,
    TGT_STAT   = 3'd4,
    TGT_CLKHI  = 3'd5,
    TGT_RESET  = 3'd6
  } tgt_e;

endpackage

// File: rtl/brg_decode.sv
module brg_decode
  import bridge_pkg::*;
(
  input  logic [WORD_W-1:0] cmd,
  output tgt_e              tgt,
  output logic              known,
  output logic              is_read
);

  logic [OP_W-1:0]  opc;
  logic [EXT_W-1:0] ext;

  assign opc     = cmd[OP_HI:OP_LO];
  assign ext     = cmd[EXT_HI:EXT_LO];
  assign is_read = cmd[READ_B];

  always_comb begin
    tgt = TGT_NONE;
    if (opc == OPC_CLKHI) begin
      tgt = TGT_CLKHI;
    end else if (opc == OPC_EXT) begin
      case (ext)
        EXT_DATA: tgt = TGT_DATA;
        EXT_CTL:  tgt = TGT_CTL;
        EXT_CKST: tgt = is_read ? TGT_STAT : TGT_CLKCTL;
        EXT_RST:  tgt = is_read ? TGT_NONE : TGT_RESET;
        default:  tgt = TGT_NONE;
      endcase
    end
  end

  assign known = (tgt != TGT_NONE);

endmodule

// File: rtl/brg_seq.sv
module brg_seq
  import bridge_pkg::*;
#(
  parameter int ACCESS_LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_known,
  input  logic start_read,
  input  tgt_e start_tgt,
  output logic done,
  output logic done_known,
  output logic done_read,
  output logic [2:0] bus_sel,
  output logic bus_wr,
  output logic bus_rd
);

  localparam int CNT_W = (ACCESS_LAT < 2) ? 1 : $clog2(ACCESS_LAT);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACCESS_LAT - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             known_q, known_d;
  logic             read_q, read_d;
  tgt_e             tgt_q, tgt_d;

  assign done       = busy_q && (cnt_q == '0);
  assign done_known = known_q;
  assign done_read  = read_q;
  assign bus_wr     = done && known_q && !read_q;
  assign bus_rd     = done && known_q && read_q;
  assign bus_sel    = (busy_q && known_q) ? tgt_q : TGT_NONE;

  always_comb begin
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    known_d = known_q;
    read_d  = read_q;
    tgt_d   = tgt_q;
    if (busy_q) begin
      if (done) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (start) begin
      busy_d  = 1'b1;
      cnt_d   = start_known ? CNT_LOAD : '0;
      known_d = start_known;
      read_d  = start_read;
      tgt_d   = start_tgt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      known_q <= 1'b0;
      read_q  <= 1'b0;
      tgt_q   <= TGT_NONE;
    end else begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      known_q <= known_d;
      read_q  <= read_d;
      tgt_q   <= tgt_d;
    end
  end

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) |=> !(bus_wr || bus_rd));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

endmodule

// File: rtl/brg_cmd_reg.sv
module brg_cmd_reg
  import bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [WORD_W-1:0] wdata,
  input  logic              done,
  input  logic              done_known,
  input  logic              done_read,
  input  logic [BYTE_W-1:0] rbyte,
  output logic [WORD_W-1:0] word
);

  logic [WORD_W-1:0] word_q, word_d;
  logic              load_en;

  assign load_en = accept || done;

  always_comb begin
    word_d = word_q;
    if (accept) begin
      word_d = wdata;
    end else if (done) begin
      word_d[BUSY_B] = 1'b0;
      if (done_read) begin
        word_d[BYTE_W-1:0] = done_known ? rbyte : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (load_en) begin
      word_q <= word_d;
    end
  end

  assign word = word_q;

  // R8
  wr_byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(word_q[BUSY_B]) && !word_q[READ_B]) |-> $stable(word_q[BYTE_W-1:0]));

  // R6
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(word_q[BUSY_B]) |-> $stable(word_q[BUSY_B-1:BYTE_W]));

endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import bridge_pkg::*;
#(
  parameter int ACCESS_LAT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [63:0] host_wdata,
  output logic [63:0] host_rdata,
  output logic [2:0]  bus_sel,
  output logic        bus_wr,
  output logic        bus_rd,
  output logic [7:0]  bus_wdata,
  input  logic [7:0]  bus_rdata
);

  logic [WORD_W-1:0] word;
  logic              accept;
  tgt_e              dec_tgt;
  logic              dec_known;
  logic              dec_read;
  logic              done;
  logic              done_known;
  logic              done_read;

  assign accept = host_we && host_wdata[BUSY_B] && !word[BUSY_B];

  brg_decode u_dec (
    .cmd     (host_wdata),
    .tgt     (dec_tgt),
    .known   (dec_known),
    .is_read (dec_read)
  );

  brg_seq #(.ACCESS_LAT(ACCESS_LAT)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .start_known (dec_known),
    .start_read  (dec_read),
    .start_tgt   (dec_tgt),
    .done        (done),
    .done_known  (done_known),
    .done_read   (done_read),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd)
  );

  brg_cmd_reg u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .wdata      (host_wdata),
    .done       (done),
    .done_known (done_known),
    .done_read  (done_read),
    .rbyte      (bus_rdata),
    .word       (word)
  );

  assign host_rdata = word;
  assign bus_wdata  = word[BYTE_W-1:0];

  // R5
  strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) |=> !host_rdata[BUSY_B]);

  // R3
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rdata[BUSY_B] && host_we) |=> $stable(host_rdata[BUSY_B-1:BYTE_W]));

  // R2
  rise_from_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_rdata[BUSY_B]) |-> $past(host_we));

  // R7
  unknown_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(host_rdata[BUSY_B]) && !$past(dec_known)) |=> !host_rdata[BUSY_B]);

endmodule

// File: tb/sim_ind_reg_bridge.sv
module sim_ind_reg_bridge;

  localparam int LAT = 3;

  logic        clk;
  logic        rst_n;
  logic        host_we;
  logic [63:0] host_wdata;
  logic [63:0] host_rdata;
  logic [2:0]  bus_sel;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  ind_reg_bridge #(.ACCESS_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  // Stub register bank on the bus side: codes 1 data,2 ctl,3 clkctl,4 stat,5 clkhi,6 reset
  logic [7:0] s_data, s_ctl, s_ckc, s_stat, s_ckh;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_data <= 0; s_ctl <= 0; s_ckc <= 0; s_stat <= 8'h55; s_ckh <= 0;
    end else if (bus_wr) begin
      case (bus_sel)
        3'd1: s_data <= bus_wdata;
        3'd2: s_ctl  <= bus_wdata;
        3'd3: s_ckc  <= bus_wdata;
        3'd5: s_ckh  <= bus_wdata;
        3'd6: begin s_data <= 0; s_ctl <= 0; s_ckc <= 0; s_ckh <= 0; s_stat <= 8'hF8; end
        default: ;
      endcase
    end
  end
  always_comb begin
    case (bus_sel)
      3'd1: bus_rdata = s_data;
      3'd2: bus_rdata = s_ctl;
      3'd3: bus_rdata = s_ckc;
      3'd4: bus_rdata = s_stat;
      3'd5: bus_rdata = s_ckh;
      default: bus_rdata = 8'h00;
    endcase
  end

  // Behavioural reference model
  logic [63:0] m_word;
  int          m_busy, m_cnt, m_tgt, m_read;
  int          m_bank [0:7];

  function automatic int ref_target(input logic [63:0] c);
    int op, ex;
    op = int'(c[60:57]);
    ex = int'(c[34:32]);
    if (op == 4) return 5;
    if (op != 6) return 0;
    if (ex == 1) return 1;
    if (ex == 2) return 2;
    if (ex == 3) return c[56] ? 4 : 3;
    if (ex == 7) return c[56] ? 0 : 6;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_word = 0; m_busy = 0; m_cnt = 0; m_tgt = 0; m_read = 0;
      for (int i = 0; i < 8; i++) m_bank[i] = 0;
      m_bank[4] = 8'h55;
    end else if (m_busy != 0) begin
      if (m_cnt == 0) begin
        m_word[63] = 1'b0;
        if (m_read != 0) m_word[7:0] = (m_tgt != 0) ? m_bank[m_tgt][7:0] : 8'h00;
        else if (m_tgt == 6) begin
          for (int i = 0; i < 8; i++) m_bank[i] = 0;
          m_bank[4] = 8'hF8;
        end else if (m_tgt != 0) m_bank[m_tgt] = int'(m_word[7:0]);
        m_busy = 0;
      end else m_cnt = m_cnt - 1;
    end else if (host_we && host_wdata[63]) begin
      m_word = host_wdata;
      m_tgt  = ref_target(host_wdata);
      m_read = host_wdata[56] ? 1 : 0;
      m_busy = 1;
      m_cnt  = (m_tgt != 0) ? LAT - 1 : 0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model (R2, R5, R6)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic ew, er;
      ew = (m_busy != 0) && (m_cnt == 0) && (m_tgt != 0) && (m_read == 0);
      er = (m_busy != 0) && (m_cnt == 0) && (m_tgt != 0) && (m_read != 0);
      check(host_rdata == m_word, "R2/R6 word", host_rdata, m_word);
      check(bus_wr == ew && bus_rd == er, "R5 strobe", {bus_wr, bus_rd}, {ew, er});
      if (ew || er) begin
        check(bus_sel == 3'(m_tgt), "R4 sel", bus_sel, m_tgt);
        check(bus_wdata == m_word[7:0], "R5 wdata", bus_wdata, m_word[7:0]);
      end
    end
  end

  function automatic logic [63:0] mk(input bit rd, input int op, input int ex, input logic [7:0] d);
    logic [63:0] c;
    c = 0;
    c[63] = 1'b1;
    c[56] = rd;
    c[60:57] = 4'(op);
    c[34:32] = 3'(ex);
    c[7:0] = d;
    return c;
  endfunction

  task automatic issue(input logic [63:0] c, output int busy_cycles);
    @(negedge clk);
    host_we = 1; host_wdata = c;
    @(negedge clk);
    host_we = 0;
    busy_cycles = 0;
    while (host_rdata[63] && busy_cycles < 1000) begin
      busy_cycles++;
      @(negedge clk);
    end
  endtask

  task automatic do_read(input int op, input int ex, input logic [7:0] exp, input string req);
    int bc;
    logic [63:0] c, e;
    c = mk(1, op, ex, 8'hC3);
    issue(c, bc);
    e = c; e[63] = 0; e[7:0] = exp;
    check(host_rdata == e, req, host_rdata, e);
  endtask

  initial begin
    int bc;
    logic [63:0] c, snap;
    rst_n = 0; host_we = 0; host_wdata = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(host_rdata == 0 && !bus_wr && !bus_rd, "R1", host_rdata, 0);
    rst_n = 1;
    @(negedge clk);
    check(host_rdata == 0 && !bus_wr && !bus_rd, "R1", host_rdata, 0);

    // R2: busy length, R8: written byte stays
    c = mk(0, 6, 1, 8'hA5);
    issue(c, bc);
    check(bc == LAT, "R2 busy cycles", bc, LAT);
    check(host_rdata[7:0] == 8'hA5, "R8 write byte kept", host_rdata[7:0], 8'hA5);
    do_read(6, 1, 8'hA5, "R6 read data");

    // R4: each target
    issue(mk(0, 6, 2, 8'h3C), bc);
    do_read(6, 2, 8'h3C, "R4 control");
    issue(mk(0, 6, 3, 8'h5A), bc);
    do_read(6, 3, 8'h55, "R4 ext3 read is status");
    issue(mk(0, 4, 5, 8'h18), bc);
    do_read(4, 0, 8'h18, "R4 clock high");

    // R3: write during busy ignored
    @(negedge clk);
    host_we = 1; host_wdata = mk(0, 6, 1, 8'h11);
    @(negedge clk);
    host_wdata = mk(0, 6, 2, 8'h22);
    @(negedge clk);
    host_wdata = mk(0, 4, 0, 8'h33);
    @(negedge clk);
    host_we = 0;
    check(host_rdata == mk(0, 6, 1, 8'h11) && host_rdata[63], "R3 busy ignore", host_rdata, mk(0, 6, 1, 8'h11));
    while (host_rdata[63]) @(negedge clk);
    do_read(6, 2, 8'h3C, "R3 control untouched");
    do_read(4, 0, 8'h18, "R3 clock high untouched");
    // R3: write with busy flag clear ignored
    snap = host_rdata;
    @(negedge clk);
    host_we = 1; host_wdata = 64'h0000_0000_0000_0077;
    @(negedge clk);
    host_we = 0;
    check(host_rdata == snap, "R3 no busy flag", host_rdata, snap);

    // R7: unrecognised pairs
    c = mk(1, 2, 1, 8'h99);
    issue(c, bc);
    check(bc == 1, "R7 fast completion", bc, 1);
    check(host_rdata[7:0] == 8'h00, "R7 zero data", host_rdata[7:0], 0);
    c = mk(1, 6, 7, 8'h99);
    issue(c, bc);
    check(bc == 1 && host_rdata[7:0] == 0, "R7 read of reset", host_rdata[7:0], 0);
    c = mk(0, 6, 5, 8'h44);
    issue(c, bc);
    check(bc == 1, "R7 unknown write", bc, 1);

    // R8: read data stable
    do_read(6, 1, 8'h11, "R8 read before hold");
    snap = host_rdata;
    repeat (10) @(negedge clk);
    check(host_rdata == snap, "R8 hold", host_rdata, snap);

    // R9: core reset then status
    issue(mk(0, 6, 7, 8'h00), bc);
    check(bc == LAT, "R9 reset busy", bc, LAT);
    do_read(6, 3, 8'hF8, "R9 status after reset");
    do_read(6, 1, 8'h00, "R9 data cleared");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    finished = 1;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule